// File: doc/BRIEF.md
# Branch Clock Gate Unit

This block distributes one base clock to a set of branch clocks. Each branch has a 32-bit configuration word on a simple APB-style register port. Branch 0 is the bus branch of the domain. All higher branches are peripheral branches that sit behind it. Each branch output is the base clock, or half of it on branches built with a divider, gated by a run control.

The enable that drives each gate is captured while the selected source is low. A change to the run control therefore never shortens an output pulse. An auto-stop control lets a branch go quiet on its own idle request, so software can set that control first and clear the run bit in a later write. The halving request is a write-only bit. Software learns the active setting from a separate read-only status bit, which changes only when the divided clock is low. The register port can only complete an access while the base clock is present, which is signalled by `base_ok`.

Top module: `brg_unit`

## Requirements
- R1: After reset every branch word reads 0x0000_0001 (run=1, auto-stop=0, halving status=0), and every branch output toggles with the base clock undivided.
- R2: With the run bit (bit 0) clear, a branch output stays low. With it set, the output follows its source with whole pulses only, because the enable is captured while the source is low.
- R3: With auto-stop (bit 1) set and the branch idle input high, the output stays low. With the idle input low it runs. With auto-stop clear, the idle input has no effect.
- R4: The halving request (bit 5) is write-only and always reads 0. The halving status (bit 27) is read-only, ignores writes, and reads 1 exactly when the branch output runs at half rate. A read-modify-write that copies bit 27 into bit 5 keeps the branch divided.
- R5: On a divider-capable branch, a new halving request reaches the status bit and the output only at a rising base-clock edge where the divided clock is low. The divided output is high in every other base period.
- R6: On a branch built without a divider, bits 5 and 27 read 0, writes to them are ignored, and the output is never divided.
- R7: While `base_ok` is low, `pready` is low, no write takes effect, and every branch output stops.
- R8: A peripheral branch output stops whenever the bus branch is not running, whatever its own run bit says.
- R9: Branch n sits at byte offset 4*n, with the bus branch at offset 0. Offsets past the last branch read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock source |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_ok | input | 1 | High while the base clock is running |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address of the branch word |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Access completes when high |
| br_idle | input | NUM_BR | Per-branch idle request, used under auto-stop |
| br_clk | output | NUM_BR | Gated branch clocks, bit 0 is the bus branch |

## Verification
The bench samples every branch output in both phases of four base periods. From these samples it tells a full-rate clock, a half-rate clock and a stopped branch apart. A gate that lost its low-phase capture, or a mux that ignored the status bit, shows up as a wrong high or low count. Directed cases cover the corner cases that a faulty design gets wrong. A readback that exposed bit 5 shows up on the bus. A status bit written straight from the bus would change without a halving request. Non-divider branches must ignore bits 5 and 27. An idle request must have no effect with auto-stop clear. A child that did not follow its parent keeps clocking after the bus branch stops. A write that is not stalled while the base clock is absent changes a register when it should not. Random writes with random idle patterns then compare every word and every output against a model of the requirements.

// File: rtl/brg_pkg.sv
package brg_pkg;

    // Bit positions inside a branch word; software decodes these.
    localparam int RUN_BIT   = 0;
    localparam int AUTO_BIT  = 1;
    localparam int HALF_BIT  = 5;
    localparam int HSTAT_BIT = 27;

    typedef struct packed {
        logic run;        // branch enabled
        logic idle_gate;  // stop while the idle input is high
        logic half_req;   // requested divide-by-two (write-only)
    } br_cfg_t;

    function automatic logic [31:0] read_word(br_cfg_t cfg, logic half_stat);
        logic [31:0] w;
        w            = '0;
        w[RUN_BIT]   = cfg.run;
        w[AUTO_BIT]  = cfg.idle_gate;
        w[HSTAT_BIT] = half_stat;
        return w;
    endfunction

endpackage

// File: rtl/brg_regs.sv
module brg_regs #(
    parameter int                NUM_BR  = 5,
    parameter int                ADDR_W  = 8,
    parameter logic [NUM_BR-1:0] DIV_CAP = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          base_ok,
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [ADDR_W-1:0]             paddr,
    input  logic [31:0]                   pwdata,
    output logic [31:0]                   prdata,
    output logic                          pready,
    input  logic [NUM_BR-1:0]             half_stat,
    output brg_pkg::br_cfg_t [NUM_BR-1:0] cfg
);
    import brg_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        br_cfg_t [NUM_BR-1:0] cfg;
    } state_t;

    state_t           st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic             wr_fire;
    logic             unused_bits;

    assign idx         = paddr[ADDR_W-1:2];
    assign pready      = base_ok;
    assign wr_fire     = psel && penable && pwrite && base_ok;
    assign unused_bits = ^{paddr[1:0], pwdata[31:HSTAT_BIT], pwdata[HSTAT_BIT-1:HALF_BIT+1],
                           pwdata[HALF_BIT-1:AUTO_BIT+1]};

    always_comb begin
        st_d = st_q;
        if (wr_fire) begin
            for (int i = 0; i < NUM_BR; i++) begin
                if (idx == IDX_W'(i)) begin
                    st_d.cfg[i].run       = pwdata[RUN_BIT];
                    st_d.cfg[i].idle_gate = pwdata[AUTO_BIT];
                    st_d.cfg[i].half_req  = DIV_CAP[i] ? pwdata[HALF_BIT] : 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BR; i++) begin
                st_q.cfg[i] <= '{run: 1'b1, idle_gate: 1'b0, half_req: 1'b0};
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        prdata = '0;
        for (int i = 0; i < NUM_BR; i++) begin
            if (idx == IDX_W'(i)) prdata = read_word(st_q.cfg[i], half_stat[i]);
        end
    end

    assign cfg = st_q.cfg;

    AST_NO_WRITE_WITHOUT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        !base_ok |=> $stable(st_q)); // R7

    AST_CHANGE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != $past(st_q)) |-> $past(psel && penable && pwrite && base_ok)); // R9

endmodule

// File: rtl/brg_div.sv
module brg_div #(
    parameter int                NUM_BR  = 5,
    parameter logic [NUM_BR-1:0] DIV_CAP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BR-1:0] half_req,
    output logic              half_clk,
    output logic [NUM_BR-1:0] half_stat
);
    typedef struct packed {
        logic              half;
        logic [NUM_BR-1:0] stat;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.half = ~st_q.half;
        // Switch only while the divided clock is low.
        if (!st_q.half) st_d.stat = half_req & DIV_CAP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign half_clk  = st_q.half;
    assign half_stat = st_q.stat;

    AST_HSTAT_AT_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat != $past(st_q.stat)) |-> !$past(st_q.half)); // R5

endmodule

// File: rtl/brg_gate.sv
module brg_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic half_clk,
    input  logic divided,
    input  logic want_on,
    output logic gclk
);
    logic en_d, en_q;
    logic src;

    assign src = divided ? half_clk : clk;

    // Capture only while the selected source is low in the next phase.
    always_comb begin
        en_d = en_q;
        if (!divided || !half_clk) en_d = want_on;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign gclk = src & en_q;

    AST_GATE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!want_on && $past(!want_on) && $past(!want_on, 2) && $past(!want_on, 3)) |-> !en_q); // R2

endmodule

// File: rtl/brg_unit.sv
module brg_unit #(
    parameter int                NUM_BR  = 5,
    parameter int                ADDR_W  = 8,
    parameter logic [NUM_BR-1:0] DIV_CAP = 5'b01100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_ok,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    input  logic [NUM_BR-1:0] br_idle,
    output logic [NUM_BR-1:0] br_clk
);
    import brg_pkg::*;

    br_cfg_t [NUM_BR-1:0] cfg;
    logic    [NUM_BR-1:0] half_req;
    logic    [NUM_BR-1:0] half_stat;
    logic    [NUM_BR-1:0] want_on;
    logic                 half_clk;
    logic                 bus_on;

    brg_regs #(.NUM_BR(NUM_BR), .ADDR_W(ADDR_W), .DIV_CAP(DIV_CAP)) u_regs (
        .clk, .rst_n, .base_ok, .psel, .penable, .pwrite, .paddr, .pwdata,
        .prdata, .pready, .half_stat, .cfg
    );

    brg_div #(.NUM_BR(NUM_BR), .DIV_CAP(DIV_CAP)) u_div (
        .clk, .rst_n, .half_req, .half_clk, .half_stat
    );

    assign bus_on = base_ok && cfg[0].run && !(cfg[0].idle_gate && br_idle[0]);

    for (genvar g = 0; g < NUM_BR; g++) begin : g_br
        assign half_req[g] = cfg[g].half_req;
        if (g == 0) begin : g_bus
            assign want_on[g] = bus_on;
        end else begin : g_child
            assign want_on[g] = bus_on && cfg[g].run && !(cfg[g].idle_gate && br_idle[g]);
        end
        brg_gate u_gate (
            .clk, .rst_n, .half_clk,
            .divided (half_stat[g]),
            .want_on (want_on[g]),
            .gclk    (br_clk[g])
        );
    end

endmodule

// File: tb/sim_brg_unit.sv
module sim_brg_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 5;
    localparam int AW = 8;
    localparam logic [NB-1:0] CAP = 5'b01100;

    logic clk = 1'b0, rst_n = 1'b0, base_ok = 1'b1;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic pready;
    logic [NB-1:0] br_idle = '0, br_clk;

    int checks = 0, errors = 0;
    bit done = 0;
    bit m_run [NB], m_gate [NB], m_div [NB];
    int hi_cnt [NB], lo_cnt [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    brg_unit #(.NUM_BR(NB), .ADDR_W(AW), .DIV_CAP(CAP)) u0 (.*);

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit br_on(int b);
        bit bus = base_ok && m_run[0] && !(m_gate[0] && br_idle[0]);
        if (b == 0) return bus;
        return bus && m_run[b] && !(m_gate[b] && br_idle[b]);
    endfunction

    // high-phase count * 8 + low-phase count over four periods
    function automatic int exp_pattern(int b);
        if (!br_on(b)) return 0;
        return m_div[b] ? 2*8 + 2 : 4*8;
    endfunction

    function automatic int exp_word(int b);
        return ((m_div[b] ? 1 : 0) << 27) | ((m_gate[b] ? 1 : 0) << 1) | (m_run[b] ? 1 : 0);
    endfunction

    task automatic apb(bit wr, int b, logic [31:0] data, output logic [31:0] rd);
        @(posedge clk); #2;
        psel = 1; penable = 0; pwrite = wr; paddr = AW'(b * 4); pwdata = data;
        @(posedge clk); #2;
        penable = 1;
        forever begin
            @(posedge clk);
            if (pready) break;
        end
        rd = prdata;
        #2; psel = 0; penable = 0;
    endtask

    task automatic wr_br(int b, logic [31:0] data);
        logic [31:0] rd;
        apb(1'b1, b, data, rd);
        if (b < NB) begin
            m_run[b] = data[0]; m_gate[b] = data[1]; m_div[b] = CAP[b] && data[5];
        end
    endtask

    task automatic rd_br(int b, output logic [31:0] rd);
        apb(1'b0, b, 32'h0, rd);
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
    endtask

    task automatic measure();
        for (int b = 0; b < NB; b++) begin hi_cnt[b] = 0; lo_cnt[b] = 0; end
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            for (int b = 0; b < NB; b++) hi_cnt[b] += br_clk[b];
            @(negedge clk); #1;
            for (int b = 0; b < NB; b++) lo_cnt[b] += br_clk[b];
        end
    endtask

    task automatic check_outputs(string req);
        measure();
        for (int b = 0; b < NB; b++)
            chk(hi_cnt[b]*8 + lo_cnt[b] == exp_pattern(b), req, hi_cnt[b]*8 + lo_cnt[b], exp_pattern(b));
    endtask

    task automatic check_words(string req);
        logic [31:0] rd;
        for (int b = 0; b < NB; b++) begin
            rd_br(b, rd);
            chk(rd == 32'(exp_word(b)), req, rd, exp_word(b));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'h1234_5EED));
        for (int b = 0; b < NB; b++) begin m_run[b] = 1; m_gate[b] = 0; m_div[b] = 0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        settle();

        // R1: reset words and full-rate outputs
        check_words("R1");
        check_outputs("R1");

        // R6: non-divider branch ignores bits 5 and 27
        wr_br(1, 32'h0800_0021);
        rd_br(1, rd);
        chk(rd == 32'h1, "R6", rd, 32'h1);
        settle(); check_outputs("R6");

        // R4/R5: halving on a divider branch, bit 5 hidden, bit 27 shows status
        wr_br(2, 32'h0000_0021);
        settle();
        rd_br(2, rd);
        chk(rd == 32'h0800_0001, "R4", rd, 32'h0800_0001);
        check_outputs("R5");

        // R4: read-modify-write copying bit 27 into bit 5 keeps halving
        rd_br(2, rd);
        wr_br(2, (rd | 32'h2) | (rd[27] ? 32'h20 : 32'h0));
        settle();
        rd_br(2, rd);
        chk(rd == 32'h0800_0003, "R4", rd, 32'h0800_0003);
        check_outputs("R4");
        wr_br(2, 32'h1);
        settle(); check_outputs("R5");

        // R2: run bit cleared stops the branch
        wr_br(3, 32'h0);
        settle(); check_outputs("R2");
        wr_br(3, 32'h1);

        // R3: auto-stop with idle
        wr_br(1, 32'h3);
        @(posedge clk); #2 br_idle = 5'b00010;
        settle(); check_outputs("R3");
        @(posedge clk); #2 br_idle = 5'b00000;
        settle(); check_outputs("R3");
        wr_br(1, 32'h1);
        @(posedge clk); #2 br_idle = 5'b00010;
        settle(); check_outputs("R3");
        @(posedge clk); #2 br_idle = 5'b00000;

        // R8: bus branch stopped stops every child
        wr_br(0, 32'h0);
        settle(); check_outputs("R8");
        wr_br(0, 32'h1);
        settle(); check_outputs("R8");

        // R9: offset past the last branch
        rd_br(NB, rd);
        chk(rd == 32'h0, "R9", rd, 32'h0);
        wr_br(NB, 32'h0);
        check_words("R9");

        // R7: base clock absent stalls access
        @(posedge clk); #2;
        base_ok = 0; psel = 1; pwrite = 1; penable = 0; paddr = 8'd4; pwdata = 32'h0;
        @(posedge clk); #2 penable = 1;
        repeat (5) @(posedge clk);
        #1 chk(pready == 1'b0, "R7", pready, 0);
        check_outputs("R7");
        @(posedge clk); #2 psel = 0; penable = 0; base_ok = 1;
        settle();
        rd_br(1, rd);
        chk(rd == 32'(exp_word(1)), "R7", rd, exp_word(1));

        // Random writes and idle patterns (R2 R3 R4 R5 R6 R8)
        for (int it = 0; it < 40; it++) begin
            int b;
            logic [31:0] d;
            b = ($urandom % 4 == 0) ? 0 : 1 + ($urandom % (NB - 1));
            d = $urandom;
            d[0] = ($urandom % 4 != 0);
            wr_br(b, d);
            @(posedge clk); #2 br_idle = NB'($urandom);
            settle();
            check_outputs("R2_R3_R5_R8 random");
            check_words("R4_R6 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule